// File: doc/BRIEF.md
# Hold-Phase PWM Generator

This block drives the pulse-width-modulated hold signal for a single actuator. A free-running clock is divided by a power-of-two prescaler whose ratio comes from a small code. Each prescaler tick advances an 8-bit frame counter, which runs from zero up to a programmable top value and then wraps. The output is high from the start of each frame until the counter reaches the duty value.

Duty, top value and divider code come from a register file outside the block. Duty and top value are captured into shadow registers only at the frame wrap, so a rewrite never produces a torn pulse. The divider code is used directly. When software changes the code it pulses a re-initialise strobe, which clears the prescaler so that the new ratio starts from a clean count. An enable input gates the whole block.

Top module: `hold_pwm_gen`

## Requirements
- R1: A divider code c in 2..15 gives one frame-counter step every 2^(c-1) input clocks (code 2 steps every 2 clocks, code 15 every 16384). Codes 0 and 1 behave as code 2.
- R2: The frame counter counts 0, 1, ..., T and then returns to 0, where T is the active top value. One output period therefore lasts (T+1)*2^(c-1) clocks.
- R3: The output is high while the frame count is below the active duty D. It rises when the count restarts at 0, falls when the count reaches D, and stays high for D*2^(c-1) clocks per period.
- R4: With D = 0 the output stays low. With D > T the output stays high for as long as the block is enabled. With D = T the output is low during the single count T of each frame.
- R5: While `reinit` is high the prescaler is held at zero, so the frame counter does not advance. The first step after `reinit` falls comes a full 2^(c-1) clocks later.
- R6: Writes to `duty_in` and `top_in` take effect only at a frame wrap. A frame that is already running finishes with the values it started with.
- R7: When `enable` is low, `pwm_out` is low in the same cycle and the counter and prescaler are held at zero. The shadow duty and top values are kept. Raising `enable` starts a frame at count 0.
- R8: After reset the shadow duty is 127 and the shadow top value is 254. These values govern the first frame, until the first wrap loads `duty_in` and `top_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the generator; low forces the output low and holds the counters at zero |
| reinit | input | 1 | Clears the prescaler; pulse it after changing `div_code` |
| duty_in | input | 8 | Duty compare value, captured at frame wrap |
| top_in | input | 8 | Frame counter top value, captured at frame wrap |
| div_code | input | 4 | Prescaler code, ratio 2^(code-1) |
| pwm_out | output | 1 | Hold PWM output |

## Verification
`pwm_out` is a combinational function of registered state and `enable`, so an enable change shows at the output in the same cycle. A counter step shows exactly one prescaler ratio after the tick that causes it. The bench drives inputs and samples one nanosecond after each falling edge. Every edge-to-edge count is therefore a whole number of clocks, and the bench predicts it as D*ratio or (T+1)*ratio. Steady-state vectors wait out two worst-case frames after each change before a window of exactly one period (or two periods when counting rising edges). The phase of the window then cannot change the count. Directed tests measure from a known start instead: the first sample after enable rises, after `reinit` falls, or at a detected rising edge of the output.

// File: rtl/hold_pwm_pkg.sv
package hold_pwm_pkg;

  // Clamp a divider code into the supported range (R1).
  function automatic int unsigned clamp_code(input int unsigned code,
                                             input int unsigned lo,
                                             input int unsigned hi);
    int unsigned c;
    c = code;
    if (c < lo) c = lo;
    if (c > hi) c = hi;
    return c;
  endfunction

  // Last prescaler count value before a tick: 2^(c-1) - 1 (R1).
  function automatic int unsigned presc_last(input int unsigned code,
                                             input int unsigned lo,
                                             input int unsigned hi);
    int unsigned c;
    c = clamp_code(code, lo, hi);
    return (32'd1 << (c - 1)) - 32'd1;
  endfunction

  // Output level for a given frame count and duty (R3, R4).
  function automatic logic level_for(input int unsigned count,
                                     input int unsigned duty);
    return count < duty;
  endfunction

  // Frame is at its last count.
  function automatic logic at_top(input int unsigned count,
                                  input int unsigned top);
    return count >= top;
  endfunction

endpackage

// File: rtl/hold_pwm_prescaler.sv
module hold_pwm_prescaler
  import hold_pwm_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int MIN_CODE = 2,
  parameter int MAX_CODE = 15,
  parameter int PRE_W    = MAX_CODE - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              reinit,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_last;
  logic             clear_now;

  assign pre_last  = PRE_W'(presc_last(int'(code), MIN_CODE, MAX_CODE));
  assign clear_now = !run || reinit;
  assign tick      = !clear_now && (pre_cnt >= pre_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pre_cnt <= '0;
    else if (clear_now)      pre_cnt <= '0;
    else if (tick)           pre_cnt <= '0;
    else                     pre_cnt <= pre_cnt + 1'b1;
  end

  // R5: the strobe leaves the prescaler at zero
  assert_reinit_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> pre_cnt == '0);

  // R1: the smallest ratio is 2, so ticks never come back to back
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R7: a stopped generator holds the prescaler at zero
  assert_idle_presc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> pre_cnt == '0);

endmodule

// File: rtl/hold_pwm_frame.sv
module hold_pwm_frame
  import hold_pwm_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int DEF_DUTY = 127,
  parameter int DEF_TOP  = 254
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] duty_in,
  input  logic [CNT_W-1:0] top_in,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] duty_act,
  output logic [CNT_W-1:0] top_act,
  output logic             wrap
);

  localparam logic [CNT_W-1:0] DUTY_RST = CNT_W'(DEF_DUTY);
  localparam logic [CNT_W-1:0] TOP_RST  = CNT_W'(DEF_TOP);

  assign wrap = tick && at_top(int'(count), int'(top_act));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count <= '0;
    else if (!run)       count <= '0;
    else if (wrap)       count <= '0;
    else if (tick)       count <= count + 1'b1;
  end

  // Shadow registers: loaded only at the frame wrap (R6, R8)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_act <= DUTY_RST;
      top_act  <= TOP_RST;
    end else if (wrap) begin
      duty_act <= duty_in;
      top_act  <= top_in;
    end
  end

  // R2: the count never passes the active top
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= top_act);

  // R2: a wrap returns the counter to zero
  assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> count == '0);

  // R6: shadows hold between wraps
  assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(duty_act) && $stable(top_act)));

  // R7: the counter is held at zero while stopped
  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> count == '0);

endmodule

// File: rtl/hold_pwm_compare.sv
module hold_pwm_compare
  import hold_pwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] duty_act,
  input  logic [CNT_W-1:0] top_act,
  output logic             pwm
);

  logic full_on;
  logic full_off;
  logic level;

  assign full_on  = duty_act > top_act;
  assign full_off = duty_act == '0;
  assign level    = level_for(int'(count), int'(duty_act));
  assign pwm      = run && level;

  // R4: duty above the top keeps the output high while running
  assert_full_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && full_on) |-> pwm);

  // R4: zero duty keeps the output low
  assert_full_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    full_off |-> !pwm);

  // R3: every running frame with nonzero duty starts high
  assert_high_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && count == '0 && !full_off) |-> pwm);

  // R7: output low whenever stopped
  assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !pwm);

endmodule

// File: rtl/hold_pwm_gen.sv
module hold_pwm_gen #(
  parameter int CNT_W    = 8,
  parameter int CODE_W   = 4,
  parameter int MIN_CODE = 2,
  parameter int MAX_CODE = 15,
  parameter int DEF_DUTY = 127,
  parameter int DEF_TOP  = 254
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              reinit,
  input  logic [CNT_W-1:0]  duty_in,
  input  logic [CNT_W-1:0]  top_in,
  input  logic [CODE_W-1:0] div_code,
  output logic              pwm_out
);

  localparam int PRE_W = MAX_CODE - 1;

  logic             step_tick;
  logic             frame_wrap;
  logic [CNT_W-1:0] frame_cnt;
  logic [CNT_W-1:0] duty_sh;
  logic [CNT_W-1:0] top_sh;

  hold_pwm_prescaler #(
    .CODE_W  (CODE_W),
    .MIN_CODE(MIN_CODE),
    .MAX_CODE(MAX_CODE),
    .PRE_W   (PRE_W)
  ) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (enable),
    .reinit(reinit),
    .code  (div_code),
    .tick  (step_tick)
  );

  hold_pwm_frame #(
    .CNT_W   (CNT_W),
    .DEF_DUTY(DEF_DUTY),
    .DEF_TOP (DEF_TOP)
  ) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (enable),
    .tick    (step_tick),
    .duty_in (duty_in),
    .top_in  (top_in),
    .count   (frame_cnt),
    .duty_act(duty_sh),
    .top_act (top_sh),
    .wrap    (frame_wrap)
  );

  hold_pwm_compare #(
    .CNT_W(CNT_W)
  ) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (enable),
    .count   (frame_cnt),
    .duty_act(duty_sh),
    .top_act (top_sh),
    .pwm     (pwm_out)
  );

  // R2: a wrap is always a counter step
  assert_wrap_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |-> step_tick);

  // R5: no counter step while the strobe is high
  assert_no_step_in_reinit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |-> !step_tick);

endmodule

// File: tb/hold_pwm_gen_tb.sv
`timescale 1ns/1ps
module hold_pwm_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable;
  logic       reinit;
  logic [7:0] duty_in;
  logic [7:0] top_in;
  logic [3:0] div_code;
  logic       pwm_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  hold_pwm_gen u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .reinit  (reinit),
    .duty_in (duty_in),
    .top_in  (top_in),
    .div_code(div_code),
    .pwm_out (pwm_out)
  );

  // code, duty, top
  localparam int NV = 7;
  localparam int VEC [NV][3] = '{
    '{2, 3, 9},
    '{3, 5, 5},
    '{4, 1, 3},
    '{2, 0, 7},
    '{3, 9, 4},
    '{1, 4, 6},
    '{2, 200, 255}
  };

  function automatic int ratio_of(input int code);
    int c;
    c = (code < 2) ? 2 : code;
    return 1 << (c - 1);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic count_high(output int n);
    n = 0;
    while (pwm_out && n < 40000) begin
      n++;
      step();
    end
  endtask

  task automatic count_low(output int n);
    n = 0;
    while (!pwm_out && n < 40000) begin
      n++;
      step();
    end
  endtask

  task automatic wait_rise();
    logic prev;
    int guard;
    prev = pwm_out;
    guard = 0;
    forever begin
      step();
      guard++;
      if ((!prev && pwm_out) || guard > 40000) break;
      prev = pwm_out;
    end
  endtask

  initial begin
    int n;
    int h;
    int r;
    logic prev;
    rst_n = 1'b0; enable = 1'b0; reinit = 1'b0;
    duty_in = 8'd3; top_in = 8'd9; div_code = 4'd2;
    repeat (3) step();
    check("R7 reset output low", int'(pwm_out), 0);
    rst_n = 1'b1;
    step();

    // R8: first frame uses the reset shadows 127/254 at ratio 2
    enable = 1'b1;
    #1;
    count_high(n);
    check("R8 default duty high time", n, 127 * 2);
    count_low(n);
    check("R8 default top low time", n, (255 - 127) * 2);
    count_high(n);
    check("R6 loaded at first wrap", n, 3 * 2);

    // Steady-state vectors (R1 R2 R3 R4)
    for (int i = 0; i < NV; i++) begin
      int rat;
      int per;
      int hi;
      int rises;
      rat = ratio_of(VEC[i][0]);
      per = (VEC[i][2] + 1) * rat;
      hi  = ((VEC[i][1] > VEC[i][2]) ? (VEC[i][2] + 1) : VEC[i][1]) * rat;
      rises = (VEC[i][1] == 0 || VEC[i][1] > VEC[i][2]) ? 0 : 2;
      duty_in = 8'(VEC[i][1]); top_in = 8'(VEC[i][2]); div_code = 4'(VEC[i][0]);
      reinit = 1'b1;
      step();
      reinit = 1'b0;
      repeat (4200) step();
      h = 0;
      repeat (per) begin
        step();
        if (pwm_out) h++;
      end
      check($sformatf("R3 R4 R1 high per period vec%0d", i), h, hi);
      r = 0;
      prev = pwm_out;
      repeat (2 * per) begin
        step();
        if (!prev && pwm_out) r++;
        prev = pwm_out;
      end
      check($sformatf("R2 R4 rises in two periods vec%0d", i), r, rises);
    end

    // R6: duty written mid-frame waits for the wrap
    duty_in = 8'd3; top_in = 8'd9; div_code = 4'd2;
    reinit = 1'b1; step(); reinit = 1'b0;
    repeat (4200) step();
    wait_rise();
    n = 0;
    while (pwm_out && n < 1000) begin
      n++;
      if (n == 2) duty_in = 8'd7;
      step();
    end
    check("R6 running frame keeps old duty", n, 6);
    wait_rise();
    count_high(n);
    check("R6 next frame uses new duty", n, 14);

    // R7: disable forces low at once; re-enable starts at count 0
    wait_rise();
    step(); step();
    enable = 1'b0;
    #1;
    check("R7 low in disable cycle", int'(pwm_out), 0);
    repeat (5) step();
    check("R7 stays low while disabled", int'(pwm_out), 0);
    enable = 1'b1;
    #1;
    count_high(n);
    check("R7 re-enable full pulse", n, 14);

    // R5: held strobe freezes the counter
    enable = 1'b0; step();
    enable = 1'b1; reinit = 1'b1;
    h = 0;
    repeat (40) begin
      step();
      if (pwm_out) h++;
    end
    check("R5 frozen while strobe high", h, 40);
    reinit = 1'b0;
    #1;
    count_high(n);
    check("R5 full pulse after strobe", n, 14);

    // R1: top code 15, ratio 16384
    duty_in = 8'd1; top_in = 8'd1;
    repeat (4200) step();
    enable = 1'b0; div_code = 4'd15; step();
    enable = 1'b1;
    #1;
    count_high(n);
    check("R1 code 15 high time", n, 16384);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule